// File: doc/BRIEF.md
# Indexed Bank-Select Mapper with Scanline IRQ

This block is the register side of a memory mapper. It turns processor writes into bank numbers for eight 1 KB character windows and three 8 KB program windows, and it produces a mirroring selection. Programming uses two steps. A select write chooses a target index and two layout modes. A following data write stores its byte into the window, or window pair, that the index and the modes pick. The memory devices are outside the block. It only publishes the bank numbers.

A second function is an 8-bit down-counter with a latch, an enable, a reload-request flag and a clock-source mode bit. The counter is clocked by one of two external pulses: a per-scanline pulse or a per-cycle pulse. When it expires it raises an interrupt. The interrupt stays high until software disables it.

Register decode looks only at address bits [15:12] and [1:0], so every register appears at many mirror addresses.

Top module: `idx_bank_mapper`

## Requirements
- R1: After reset all character and program bank outputs, the mirroring output and the interrupt are 0. The index, both mode bits, the latch, the counter, the enable, the reload flag and the clock mode are also 0.
- R2: A write whose address ANDed with 0xF003 equals 0x8000 is a select write. It stores data[3:0] as the index, data[6] as the program mode and data[7] as the character inversion. A data write has masked address 0x8001. Masked addresses that match no register change nothing.
- R3: A data write with index 0 puts data into character window 0 and data+1 (mod 256) into window 1. With inversion set it uses windows 4 and 5 instead. Index 1 does the same for windows 2/3, or 6/7 with inversion set.
- R4: A data write with index 2, 3, 4 or 5 loads character window 4, 5, 6 or 7. With inversion set it loads window 0, 1, 2 or 3. Index 8 always loads window 1 and index 9 always loads window 3.
- R5: Program windows are numbered 0 to 2 on the prg_bank_o output, each 8 bits wide, with window 0 in the low byte.
  - Index 6 loads window 0, or window 1 in program mode.
  - Index 7 loads window 1, or window 2 in program mode.
  - Index 15 loads window 2, or window 0 in program mode.
- R6: A data write with index 10 to 14 changes no bank output.
- R7: A write with masked address 0xA000 sets mirror_h_o to data[0]: 1 means horizontal, 0 means vertical.
- R8: A write with masked address 0xC000 stores data in the latch. It also copies the data into the counter, but only while the reload flag is set.
- R9: A write with masked address 0xC001 sets the reload flag, copies the latch into the counter and stores data[0] as the clock mode. Mode 0 counts tick_line pulses and ignores tick_cycle. Mode 1 counts tick_cycle pulses and ignores tick_line.
- R10: A write with masked address 0xE000 clears the enable and drops irq_o. A write with masked address 0xE001 sets the enable. Both writes copy the latch into the counter when the reload flag is set.
- R11: On a pulse of the selected source while enabled, a counter above 1 decrements. A counter of 1 or 0 instead raises irq_o and reloads from the latch. A write to an interrupt register in the same cycle takes the place of the pulse. irq_o stays high until an interrupt-disable write.
- R12: Every output is registered and changes on the first clock edge after the write or pulse that causes it. Without a write, a bank output never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| tick_line | input | 1 | Scanline counter pulse |
| tick_cycle | input | 1 | Cycle counter pulse |
| chr_bank_o | output | 64 | Eight character bank numbers, window 0 in bits [7:0] |
| prg_bank_o | output | 24 | Three program bank numbers, window 0 in bits [7:0] |
| mirror_h_o | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the mirroring bit follows its write;
- a disable write always drops the interrupt;
- a raised interrupt holds until it is disabled;
- no interrupt can appear without a counter pulse;
- an index-0 data write without inversion always leaves window 1 one above window 0;
- indices 10 to 14 and idle cycles leave every bank output unchanged.

Some behaviour depends on history and can only be shown by the bench's scenarios. That covers:
- the exact count of pulses to an interrupt;
- whether a latch or enable write reloaded the counter, which depends on the reload flag;
- which pulse source the clock mode picks;
- the routing of every index under both modes, including the data+1 wrap at 0xFF.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

    // Number of 1 KB character windows and 8 KB program windows.
    localparam int CHR_SLOTS = 8;
    localparam int PRG_SLOTS = 3;
    localparam int IDX_W     = 4;

    // Address decode: only bits [15:12] and [1:0] take part.
    localparam logic [15:0] DEC_MASK   = 16'hF003;
    localparam logic [15:0] A_SELECT   = 16'h8000;
    localparam logic [15:0] A_DATA     = 16'h8001;
    localparam logic [15:0] A_MIRROR   = 16'hA000;
    localparam logic [15:0] A_LATCH    = 16'hC000;
    localparam logic [15:0] A_RELOAD   = 16'hC001;
    localparam logic [15:0] A_IRQ_OFF  = 16'hE000;
    localparam logic [15:0] A_IRQ_ON   = 16'hE001;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SELECT,
        OP_DATA,
        OP_MIRROR,
        OP_LATCH,
        OP_RELOAD,
        OP_IRQ_OFF,
        OP_IRQ_ON
    } reg_op_e;

endpackage

// File: rtl/bank_map_decode.sv
module bank_map_decode
    import bank_map_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output reg_op_e           op
);
    logic [15:0] masked;

    assign masked = wr_addr[15:0] & DEC_MASK;

    always_comb begin
        op = OP_NONE;
        if (wr_en) begin
            case (masked)
                A_SELECT:  op = OP_SELECT;
                A_DATA:    op = OP_DATA;
                A_MIRROR:  op = OP_MIRROR;
                A_LATCH:   op = OP_LATCH;
                A_RELOAD:  op = OP_RELOAD;
                A_IRQ_OFF: op = OP_IRQ_OFF;
                A_IRQ_ON:  op = OP_IRQ_ON;
                default:   op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/bank_map_regs.sv
module bank_map_regs
    import bank_map_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  reg_op_e                       op,
    input  logic [BANK_W-1:0]             wr_data,
    output logic [CHR_SLOTS*BANK_W-1:0]   chr_bank_o,
    output logic [PRG_SLOTS*BANK_W-1:0]   prg_bank_o,
    output logic                          mirror_h_o,
    output logic [IDX_W-1:0]              sel_idx,
    output logic                          chr_inv
);
    localparam int HALF  = CHR_SLOTS / 2;
    localparam int SLOT_W = $clog2(CHR_SLOTS);
    localparam int PSEL_W = $clog2(PRG_SLOTS);

    typedef struct packed {
        logic [IDX_W-1:0]                   idx;
        logic                               prg_mode;
        logic                               chr_inv;
        logic                               mirror_h;
        logic [CHR_SLOTS-1:0][BANK_W-1:0]   chr;
        logic [PRG_SLOTS-1:0][BANK_W-1:0]   prg;
    } bank_state_t;

    bank_state_t s_d, s_q;
    logic [SLOT_W-1:0] pair_base;
    logic [SLOT_W-1:0] single_slot;
    logic [PSEL_W-1:0] prg_slot;

    always_comb begin
        s_d         = s_q;
        pair_base   = '0;
        single_slot = '0;
        prg_slot    = '0;
        case (op)
            OP_SELECT: begin
                s_d.idx      = wr_data[IDX_W-1:0];
                s_d.prg_mode = wr_data[6];
                s_d.chr_inv  = wr_data[7];
            end
            OP_MIRROR: s_d.mirror_h = wr_data[0];
            OP_DATA: begin
                case (s_q.idx)
                    4'd0, 4'd1: begin
                        // pair loads: even window gets data, odd gets data+1
                        pair_base = SLOT_W'({s_q.idx[0], 1'b0})
                                  + (s_q.chr_inv ? SLOT_W'(HALF) : SLOT_W'(0));
                        s_d.chr[pair_base]        = wr_data;
                        s_d.chr[pair_base + 1'b1] = wr_data + 1'b1;
                    end
                    4'd2, 4'd3, 4'd4, 4'd5: begin
                        single_slot = SLOT_W'(s_q.idx - 4'd2)
                                    + (s_q.chr_inv ? SLOT_W'(0) : SLOT_W'(HALF));
                        s_d.chr[single_slot] = wr_data;
                    end
                    4'd8: s_d.chr[1] = wr_data;
                    4'd9: s_d.chr[3] = wr_data;
                    4'd6: begin
                        prg_slot = s_q.prg_mode ? PSEL_W'(1) : PSEL_W'(0);
                        s_d.prg[prg_slot] = wr_data;
                    end
                    4'd7: begin
                        prg_slot = s_q.prg_mode ? PSEL_W'(2) : PSEL_W'(1);
                        s_d.prg[prg_slot] = wr_data;
                    end
                    4'd15: begin
                        prg_slot = s_q.prg_mode ? PSEL_W'(0) : PSEL_W'(2);
                        s_d.prg[prg_slot] = wr_data;
                    end
                    default: ; // indices 10..14 leave every bank untouched
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar gi = 0; gi < CHR_SLOTS; gi++) begin : g_chr_out
        assign chr_bank_o[gi*BANK_W +: BANK_W] = s_q.chr[gi];
    end
    for (genvar gp = 0; gp < PRG_SLOTS; gp++) begin : g_prg_out
        assign prg_bank_o[gp*BANK_W +: BANK_W] = s_q.prg[gp];
    end

    assign mirror_h_o = s_q.mirror_h;
    assign sel_idx    = s_q.idx;
    assign chr_inv    = s_q.chr_inv;
endmodule

// File: rtl/bank_map_irq.sv
module bank_map_irq
    import bank_map_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_op_e          op,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tick_line,
    input  logic             tick_cycle,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] latch;
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             reload;
        logic             mode;
        logic             pend;
    } irq_state_t;

    irq_state_t s_d, s_q;
    logic       tick;

    assign tick = s_q.mode ? tick_cycle : tick_line;

    always_comb begin
        s_d = s_q;
        case (op)
            OP_LATCH: begin
                s_d.latch = wr_data;
                if (s_q.reload) s_d.cnt = wr_data;
            end
            OP_RELOAD: begin
                s_d.reload = 1'b1;
                s_d.cnt    = s_q.latch;
                s_d.mode   = wr_data[0];
            end
            OP_IRQ_OFF: begin
                s_d.en   = 1'b0;
                s_d.pend = 1'b0;
                if (s_q.reload) s_d.cnt = s_q.latch;
            end
            OP_IRQ_ON: begin
                s_d.en = 1'b1;
                if (s_q.reload) s_d.cnt = s_q.latch;
            end
            default: begin
                if (s_q.en && tick) begin
                    if (s_q.cnt <= CNT_W'(1)) begin
                        s_d.pend = 1'b1;
                        s_d.cnt  = s_q.latch;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o = s_q.pend;
endmodule

// File: rtl/idx_bank_mapper.sv
module idx_bank_mapper
    import bank_map_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BANK_W-1:0]           wr_data,
    input  logic                        tick_line,
    input  logic                        tick_cycle,
    output logic [CHR_SLOTS*BANK_W-1:0] chr_bank_o,
    output logic [PRG_SLOTS*BANK_W-1:0] prg_bank_o,
    output logic                        mirror_h_o,
    output logic                        irq_o
);
    reg_op_e          op;
    logic [IDX_W-1:0] sel_idx;
    logic             chr_inv;

    bank_map_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .op      (op)
    );

    bank_map_regs #(.BANK_W(BANK_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .wr_data    (wr_data),
        .chr_bank_o (chr_bank_o),
        .prg_bank_o (prg_bank_o),
        .mirror_h_o (mirror_h_o),
        .sel_idx    (sel_idx),
        .chr_inv    (chr_inv)
    );

    bank_map_irq #(.CNT_W(BANK_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .wr_data    (wr_data),
        .tick_line  (tick_line),
        .tick_cycle (tick_cycle),
        .irq_o      (irq_o)
    );
endmodule

// File: rtl/idx_bank_mapper_chk.sv
module idx_bank_mapper_chk
    import bank_map_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic [BANK_W-1:0]           wr_data,
    input logic                        tick_line,
    input logic                        tick_cycle,
    input logic [CHR_SLOTS*BANK_W-1:0] chr_bank_o,
    input logic [PRG_SLOTS*BANK_W-1:0] prg_bank_o,
    input logic                        mirror_h_o,
    input logic                        irq_o,
    input logic [IDX_W-1:0]            sel_idx,
    input logic                        chr_inv
);
    logic [15:0] madr;
    logic        is_data, is_mirror, is_off;

    assign madr      = wr_addr[15:0] & DEC_MASK;
    assign is_data   = wr_en && (madr == A_DATA);
    assign is_mirror = wr_en && (madr == A_MIRROR);
    assign is_off    = wr_en && (madr == A_IRQ_OFF);

    // R7: mirroring follows the written bit one cycle later
    a_r7_mirror_follows: assert property (@(posedge clk) disable iff (!rst_n)
        is_mirror |=> (mirror_h_o == $past(wr_data[0])));

    // R10: a disable write always drops the interrupt
    a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        is_off |=> !irq_o);

    // R11: a raised interrupt holds until disabled
    a_r11_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !is_off) |=> irq_o);

    // R11: no interrupt rises without a counter pulse
    a_r11_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !tick_line && !tick_cycle) |=> !irq_o);

    // R3: index 0 without inversion leaves window 1 one above window 0
    a_r3_pair_step: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data && sel_idx == 4'd0 && !chr_inv) |=>
        (chr_bank_o[2*BANK_W-1:BANK_W] == BANK_W'(chr_bank_o[BANK_W-1:0] + 1'b1)));

    // R6: indices 10..14 change no bank output
    a_r6_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data && sel_idx >= 4'd10 && sel_idx <= 4'd14) |=>
        ($stable(chr_bank_o) && $stable(prg_bank_o)));

    // R12: without a write, bank outputs do not move
    a_r12_quiet_banks: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(chr_bank_o) && $stable(prg_bank_o) && $stable(mirror_h_o)));
endmodule

bind idx_bank_mapper idx_bank_mapper_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .tick_line  (tick_line),
    .tick_cycle (tick_cycle),
    .chr_bank_o (chr_bank_o),
    .prg_bank_o (prg_bank_o),
    .mirror_h_o (mirror_h_o),
    .irq_o      (irq_o),
    .sel_idx    (sel_idx),
    .chr_inv    (chr_inv)
);

// File: tb/tb_idx_bank_mapper.sv
module tb_idx_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        tick_line = 1'b0;
    logic        tick_cycle = 1'b0;
    logic [63:0] chr_bank_o;
    logic [23:0] prg_bank_o;
    logic        mirror_h_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R1";

    // reference model state
    logic [7:0] m_chr [8];
    logic [7:0] m_prg [3];
    logic       m_mir, m_pm, m_inv, m_en, m_rel, m_mode, m_pend;
    logic [3:0] m_idx;
    logic [7:0] m_lat, m_cnt;

    idx_bank_mapper dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick_line(tick_line), .tick_cycle(tick_cycle),
        .chr_bank_o(chr_bank_o), .prg_bank_o(prg_bank_o),
        .mirror_h_o(mirror_h_o), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_chr[i] = '0;
        for (int i = 0; i < 3; i++) m_prg[i] = '0;
        m_mir = 0; m_pm = 0; m_inv = 0; m_en = 0; m_rel = 0; m_mode = 0; m_pend = 0;
        m_idx = '0; m_lat = '0; m_cnt = '0;
    endtask

    task automatic model_data(input logic [7:0] d);
        case (m_idx)
            4'd0: begin m_chr[m_inv ? 4 : 0] = d; m_chr[m_inv ? 5 : 1] = d + 8'd1; end
            4'd1: begin m_chr[m_inv ? 6 : 2] = d; m_chr[m_inv ? 7 : 3] = d + 8'd1; end
            4'd2: m_chr[m_inv ? 0 : 4] = d;
            4'd3: m_chr[m_inv ? 1 : 5] = d;
            4'd4: m_chr[m_inv ? 2 : 6] = d;
            4'd5: m_chr[m_inv ? 3 : 7] = d;
            4'd6: m_prg[m_pm ? 1 : 0] = d;
            4'd7: m_prg[m_pm ? 2 : 1] = d;
            4'd8: m_chr[1] = d;
            4'd9: m_chr[3] = d;
            4'd15: m_prg[m_pm ? 0 : 2] = d;
            default: ;
        endcase
    endtask

    task automatic model_step(input logic w, input logic [15:0] a, input logic [7:0] d,
                              input logic tl, input logic tc);
        logic [15:0] ma;
        bit irqw;
        ma = a & 16'hF003;
        irqw = 0;
        if (w) begin
            case (ma)
                16'h8000: begin m_idx = d[3:0]; m_pm = d[6]; m_inv = d[7]; end
                16'h8001: model_data(d);
                16'hA000: m_mir = d[0];
                16'hC000: begin irqw = 1; m_lat = d; if (m_rel) m_cnt = d; end
                16'hC001: begin irqw = 1; m_rel = 1; m_cnt = m_lat; m_mode = d[0]; end
                16'hE000: begin irqw = 1; m_en = 0; m_pend = 0; if (m_rel) m_cnt = m_lat; end
                16'hE001: begin irqw = 1; m_en = 1; if (m_rel) m_cnt = m_lat; end
                default: ;
            endcase
        end
        if (!irqw && m_en && (m_mode ? tc : tl)) begin
            if (m_cnt <= 8'd1) begin m_pend = 1; m_cnt = m_lat; end
            else m_cnt = m_cnt - 8'd1;
        end
    endtask

    task automatic compare();
        for (int i = 0; i < 8; i++) begin
            checks++;
            if (chr_bank_o[i*8 +: 8] !== m_chr[i]) begin
                fails++;
                $display("FAIL %s chr window %0d: actual %02h expected %02h",
                         cur_req, i, chr_bank_o[i*8 +: 8], m_chr[i]);
            end
        end
        for (int i = 0; i < 3; i++) begin
            checks++;
            if (prg_bank_o[i*8 +: 8] !== m_prg[i]) begin
                fails++;
                $display("FAIL %s prg window %0d: actual %02h expected %02h",
                         cur_req, i, prg_bank_o[i*8 +: 8], m_prg[i]);
            end
        end
        checks++;
        if (mirror_h_o !== m_mir) begin
            fails++;
            $display("FAIL %s mirror: actual %0b expected %0b", cur_req, mirror_h_o, m_mir);
        end
        checks++;
        if (irq_o !== m_pend) begin
            fails++;
            $display("FAIL %s irq: actual %0b expected %0b", cur_req, irq_o, m_pend);
        end
    endtask

    // drive at a falling edge, model at the rising edge, compare at the next falling edge
    task automatic step(input logic w, input logic [15:0] a, input logic [7:0] d,
                        input logic tl, input logic tc);
        wr_en = w; wr_addr = a; wr_data = d; tick_line = tl; tick_cycle = tc;
        @(posedge clk);
        model_step(w, a, d, tl, tc);
        @(negedge clk);
        wr_en = 0; tick_line = 0; tick_cycle = 0;
        compare();
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        compare();

        // R3: pairs, with wrap of data+1 at 0xFF
        cur_req = "R3";
        wr(16'h8000, 8'h00); wr(16'h8001, 8'hFF);
        wr(16'h8000, 8'h01); wr(16'h8001, 8'h20);
        wr(16'h8000, 8'h80); wr(16'h8001, 8'h40);
        wr(16'h8000, 8'h81); wr(16'h8001, 8'h60);

        // R4: single windows, both inversion settings, fixed indices 8 and 9
        cur_req = "R4";
        for (int k = 2; k <= 5; k++) begin
            wr(16'h8000, 8'(k));        wr(16'h8001, 8'(8'h10 + k));
            wr(16'h8000, 8'(8'h80 | k)); wr(16'h8001, 8'(8'h90 + k));
        end
        wr(16'h8000, 8'h88); wr(16'h8001, 8'hA8);
        wr(16'h8000, 8'h09); wr(16'h8001, 8'hA9);

        // R5: program windows in both program modes
        cur_req = "R5";
        wr(16'h8000, 8'h06); wr(16'h8001, 8'h31);
        wr(16'h8000, 8'h07); wr(16'h8001, 8'h32);
        wr(16'h8000, 8'h0F); wr(16'h8001, 8'h33);
        wr(16'h8000, 8'h46); wr(16'h8001, 8'h41);
        wr(16'h8000, 8'h47); wr(16'h8001, 8'h42);
        wr(16'h8000, 8'h4F); wr(16'h8001, 8'h43);

        // R6: unused indices; R2: mirror addresses and unmapped addresses
        cur_req = "R6";
        for (int k = 10; k <= 14; k++) begin
            wr(16'h8000, 8'(k)); wr(16'h8001, 8'hEE);
        end
        cur_req = "R2";
        wr(16'h8FFC, 8'h02); wr(16'h8551, 8'h77);
        wr(16'h9000, 8'h55); wr(16'h8002, 8'h66); wr(16'hB001, 8'h12);

        // R7 / R12: mirroring
        cur_req = "R7";
        wr(16'hA000, 8'h01); wr(16'hA7F4, 8'hFE); wr(16'hA000, 8'h03);
        cur_req = "R12";
        step(1'b0, 16'h0000, 8'h00, 1'b0, 1'b0);

        // R8: latch write without reload flag leaves counter at 0 -> first tick fires
        cur_req = "R8";
        wr(16'hC000, 8'h05); wr(16'hE001, 8'h00);
        step(1'b0, 16'h0, 8'h0, 1'b1, 1'b0);
        cur_req = "R10";
        wr(16'hE000, 8'h00); wr(16'hE001, 8'h00);
        cur_req = "R9";
        repeat (3) step(1'b0, 16'h0, 8'h0, 1'b0, 1'b1);
        wr(16'hC001, 8'h01);
        repeat (4) step(1'b0, 16'h0, 8'h0, 1'b1, 1'b0);
        cur_req = "R11";
        repeat (6) step(1'b0, 16'h0, 8'h0, 1'b0, 1'b1);
        // tick in the same cycle as an interrupt write is not counted
        step(1'b1, 16'hE001, 8'h00, 1'b0, 1'b1);
        cur_req = "R10";
        wr(16'hC000, 8'h02); wr(16'hE000, 8'h00); wr(16'hE001, 8'h00);
        cur_req = "R11";
        repeat (3) step(1'b0, 16'h0, 8'h0, 1'b0, 1'b1);
        wr(16'hC000, 8'h00);
        step(1'b0, 16'h0, 8'h0, 1'b0, 1'b1);

        // random phase across all registers and their mirror addresses
        cur_req = "R2";
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] a;
            logic [3:0]  pick;
            pick = 4'($urandom_range(0, 8));
            case (pick)
                4'd0: a = 16'h8000; 4'd1, 4'd2: a = 16'h8001;
                4'd3: a = 16'hA000; 4'd4: a = 16'hC000;
                4'd5: a = 16'hC001; 4'd6: a = 16'hE000;
                4'd7: a = 16'hE001; default: a = 16'h9002;
            endcase
            a = a | (16'($urandom) & 16'h0FFC);
            cur_req = (pick >= 4 && pick <= 7) ? "R11" : "R3";
            step(($urandom % 3) == 0, a, 8'($urandom),
                 ($urandom % 3) == 0, ($urandom % 3) == 0);
        end

        done = 1;
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule